// File: doc/BRIEF.md
# Segment Base and Limit Address Relocator

This block turns logical addresses into physical addresses for a processor that runs programs in relocatable segments. It holds two segments, one for instruction fetch and one for data access. Each segment is a base and a limit. A logical address that lies below its segment's limit is legal. Its physical address is the segment base plus the logical address. A logical address at or above the limit is a bounds violation.

The four segment registers are loaded through a single write port. The port takes effect only while the privileged-mode input is high. A write attempted without privilege changes nothing and raises a one-cycle illegal-write pulse.

The fetch and data lookup ports are purely combinational and fully independent. The pipeline can translate a fetch and a load/store in the same cycle with no added latency.

Top module: `seg_relocator`

## Requirements
- R1: When an access is legal, its physical address equals the segment base plus the zero-extended logical address, taken modulo 2^PA_W.
- R2: An access whose logical address is greater than or equal to its segment's limit raises that port's violation output in the same cycle. A logical address strictly below the limit does not raise it.
- R3: The fetch port uses only the program base/limit pair and the data port uses only the data base/limit pair. Both ports translate in the same cycle without affecting each other.
- R4: A register write takes effect at the clock edge where `wr_en` and `priv` are both high. The `wr_sel` encoding is 0 = program base, 1 = program limit, 2 = data base, 3 = data limit. A limit takes the low LA_W+1 bits of `wr_data`, so a limit of 2^LA_W opens the whole logical space.
- R5: A write with `wr_en` high and `priv` low leaves all four registers unchanged. It raises `illegal_wr` for exactly the one cycle after that clock edge.
- R6: While a port's violation output is high, that port's physical address output is zero.
- R7: Reset clears all four registers, so every access on both ports is a violation until the limits are programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| priv | input | 1 | Privileged (supervisor) mode; enables register writes |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 2 | Register select (0 pbase, 1 plimit, 2 dbase, 3 dlimit) |
| wr_data | input | PA_W | Write data; limits use the low LA_W+1 bits |
| if_la | input | LA_W | Fetch logical address |
| if_pa | output | PA_W | Fetch physical address |
| if_viol | output | 1 | Fetch bounds violation |
| dt_la | input | LA_W | Data logical address |
| dt_pa | output | PA_W | Data physical address |
| dt_viol | output | 1 | Data bounds violation |
| illegal_wr | output | 1 | One-cycle pulse after an unprivileged write attempt |

## Verification
The assertions assume that `priv`, `wr_en`, `wr_sel` and `wr_data` are settled at each rising edge and hold no unknown values once reset is released. They also assume that the lookup addresses are stable while the outputs are sampled. The stimulus changes every input only at the falling clock edge and keeps every input at a known value from time zero. It compares outputs one time unit after that falling edge, well clear of the edge that updates the registers. The bench runs a small configuration (4-bit logical, 6-bit physical). In this configuration it can sweep every logical address on both ports for each segment setting it programs, including settings that wrap the physical sum.

// File: rtl/relo_pkg.sv
package relo_pkg;

  // Register select codes on the write port.
  typedef enum logic [1:0] {
    SEL_PBASE = 2'd0,
    SEL_PLIM  = 2'd1,
    SEL_DBASE = 2'd2,
    SEL_DLIM  = 2'd3
  } relo_sel_e;

  localparam int unsigned SIDE_IF = 0;
  localparam int unsigned SIDE_DT = 1;
  localparam int unsigned NSIDES  = 2;

endpackage

// File: rtl/relo_rst_sync.sv
module relo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/relo_regfile.sv
module relo_regfile
  import relo_pkg::*;
#(
  parameter int unsigned LA_W = 16,
  parameter int unsigned PA_W = 24,
  localparam int unsigned LM_W = LA_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            priv,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [PA_W-1:0] wr_data,
  output logic [PA_W-1:0] pbase,
  output logic [LM_W-1:0] plim,
  output logic [PA_W-1:0] dbase,
  output logic [LM_W-1:0] dlim,
  output logic            illegal_wr
);

  relo_sel_e       sel;
  logic            wr_ok;
  logic            pbase_en, plim_en, dbase_en, dlim_en;
  logic [PA_W-1:0] pbase_q, dbase_q;
  logic [LM_W-1:0] plim_q, dlim_q;
  logic [LM_W-1:0] lim_d;
  logic            ill_q, ill_d;

  // Next-state decode.
  always_comb begin
    sel      = relo_sel_e'(wr_sel);
    wr_ok    = wr_en & priv;
    pbase_en = wr_ok && (sel == SEL_PBASE);
    plim_en  = wr_ok && (sel == SEL_PLIM);
    dbase_en = wr_ok && (sel == SEL_DBASE);
    dlim_en  = wr_ok && (sel == SEL_DLIM);
    lim_d    = wr_data[LM_W-1:0];
    ill_d    = wr_en & ~priv;
  end

  // State registers with explicit enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pbase_q <= '0;
      plim_q  <= '0;
      dbase_q <= '0;
      dlim_q  <= '0;
      ill_q   <= 1'b0;
    end else begin
      if (pbase_en) pbase_q <= wr_data;
      if (plim_en)  plim_q  <= lim_d;
      if (dbase_en) dbase_q <= wr_data;
      if (dlim_en)  dlim_q  <= lim_d;
      ill_q <= ill_d;
    end
  end

  assign pbase      = pbase_q;
  assign plim       = plim_q;
  assign dbase      = dbase_q;
  assign dlim       = dlim_q;
  assign illegal_wr = ill_q;

endmodule

// File: rtl/relo_xlate.sv
module relo_xlate #(
  parameter int unsigned LA_W = 16,
  parameter int unsigned PA_W = 24,
  localparam int unsigned LM_W = LA_W + 1
) (
  input  logic [LA_W-1:0] la,
  input  logic [PA_W-1:0] base,
  input  logic [LM_W-1:0] lim,
  output logic [PA_W-1:0] pa,
  output logic            viol
);

  logic [LM_W-1:0] la_ext;
  logic [PA_W-1:0] la_pa;
  logic [PA_W-1:0] sum;

  always_comb begin
    la_ext = {1'b0, la};
    la_pa  = PA_W'(la);
    sum    = base + la_pa;
    viol   = (la_ext >= lim);
    pa     = viol ? '0 : sum;
  end

endmodule

// File: rtl/seg_relocator.sv
module seg_relocator
  import relo_pkg::*;
#(
  parameter int unsigned LA_W = 16,
  parameter int unsigned PA_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            priv,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [PA_W-1:0] wr_data,
  input  logic [LA_W-1:0] if_la,
  output logic [PA_W-1:0] if_pa,
  output logic            if_viol,
  input  logic [LA_W-1:0] dt_la,
  output logic [PA_W-1:0] dt_pa,
  output logic            dt_viol,
  output logic            illegal_wr
);

  localparam int unsigned LM_W = LA_W + 1;

  logic            srst_n;
  logic [PA_W-1:0] pbase, dbase;
  logic [LM_W-1:0] plim, dlim;

  logic [PA_W-1:0] side_base [NSIDES];
  logic [LM_W-1:0] side_lim  [NSIDES];
  logic [LA_W-1:0] side_la   [NSIDES];
  logic [PA_W-1:0] side_pa   [NSIDES];
  logic            side_viol [NSIDES];

  relo_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  relo_regfile #(.LA_W(LA_W), .PA_W(PA_W)) u_regs (
    .clk        (clk),
    .rst_n      (srst_n),
    .priv       (priv),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .pbase      (pbase),
    .plim       (plim),
    .dbase      (dbase),
    .dlim       (dlim),
    .illegal_wr (illegal_wr)
  );

  always_comb begin
    side_base[SIDE_IF] = pbase;
    side_lim[SIDE_IF]  = plim;
    side_la[SIDE_IF]   = if_la;
    side_base[SIDE_DT] = dbase;
    side_lim[SIDE_DT]  = dlim;
    side_la[SIDE_DT]   = dt_la;
  end

  for (genvar s = 0; s < NSIDES; s++) begin : g_side
    relo_xlate #(.LA_W(LA_W), .PA_W(PA_W)) u_xl (
      .la   (side_la[s]),
      .base (side_base[s]),
      .lim  (side_lim[s]),
      .pa   (side_pa[s]),
      .viol (side_viol[s])
    );
  end

  assign if_pa   = side_pa[SIDE_IF];
  assign if_viol = side_viol[SIDE_IF];
  assign dt_pa   = side_pa[SIDE_DT];
  assign dt_viol = side_viol[SIDE_DT];

endmodule

// File: rtl/seg_relocator_chk.sv
module seg_relocator_chk #(
  parameter int unsigned LA_W = 16,
  parameter int unsigned PA_W = 24,
  localparam int unsigned LM_W = LA_W + 1
) (
  input logic            clk,
  input logic            srst_n,
  input logic            priv,
  input logic            wr_en,
  input logic [LA_W-1:0] if_la,
  input logic [PA_W-1:0] if_pa,
  input logic            if_viol,
  input logic [LA_W-1:0] dt_la,
  input logic [PA_W-1:0] dt_pa,
  input logic            dt_viol,
  input logic            illegal_wr,
  input logic [PA_W-1:0] pbase,
  input logic [LM_W-1:0] plim,
  input logic [PA_W-1:0] dbase,
  input logic [LM_W-1:0] dlim
);

  // R2: address at or above the program limit flags the fetch port
  a_r2_if_over: assert property (@(posedge clk) disable iff (!srst_n)
    ({1'b0, if_la} >= plim) |-> if_viol);

  // R2 / R3: data port follows the data limit
  a_r3_dt_over: assert property (@(posedge clk) disable iff (!srst_n)
    ({1'b0, dt_la} >= dlim) |-> dt_viol);

  // R1 / R3: legal fetch adds the program base
  a_r1_if_sum: assert property (@(posedge clk) disable iff (!srst_n)
    !if_viol |-> (if_pa == PA_W'(pbase + PA_W'(if_la))));

  // R1 / R3: legal data access adds the data base
  a_r1_dt_sum: assert property (@(posedge clk) disable iff (!srst_n)
    !dt_viol |-> (dt_pa == PA_W'(dbase + PA_W'(dt_la))));

  // R6: violation zeroes the address
  a_r6_if_zero: assert property (@(posedge clk) disable iff (!srst_n)
    if_viol |-> (if_pa == '0));
  a_r6_dt_zero: assert property (@(posedge clk) disable iff (!srst_n)
    dt_viol |-> (dt_pa == '0));

  // R4 / R5: without privilege the registers hold
  a_r4_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !priv |=> ($stable(pbase) && $stable(plim) && $stable(dbase) && $stable(dlim)));

  // R5: illegal pulse follows an unprivileged write
  a_r5_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && !priv) |=> illegal_wr);
  a_r5_cause: assert property (@(posedge clk) disable iff (!srst_n)
    !(wr_en && !priv) |=> !illegal_wr);

endmodule

bind seg_relocator seg_relocator_chk #(.LA_W(LA_W), .PA_W(PA_W)) u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .priv       (priv),
  .wr_en      (wr_en),
  .if_la      (if_la),
  .if_pa      (if_pa),
  .if_viol    (if_viol),
  .dt_la      (dt_la),
  .dt_pa      (dt_pa),
  .dt_viol    (dt_viol),
  .illegal_wr (illegal_wr),
  .pbase      (pbase),
  .plim       (plim),
  .dbase      (dbase),
  .dlim       (dlim)
);

// File: tb/seg_relocator_test.sv
module seg_relocator_test;

  localparam int unsigned PERIOD = 10;
  localparam int unsigned LA_W   = 4;
  localparam int unsigned PA_W   = 6;
  localparam int unsigned NLA    = 1 << LA_W;
  localparam int unsigned NPA    = 1 << PA_W;

  logic            clk;
  logic            rst_n;
  logic            priv;
  logic            wr_en;
  logic [1:0]      wr_sel;
  logic [PA_W-1:0] wr_data;
  logic [LA_W-1:0] if_la, dt_la;
  logic [PA_W-1:0] if_pa, dt_pa;
  logic            if_viol, dt_viol, illegal_wr;

  int compared;
  int mismatched;

  // bench model of the four registers
  int m_pb, m_pl, m_db, m_dl;

  seg_relocator #(.LA_W(LA_W), .PA_W(PA_W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .priv       (priv),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .if_la      (if_la),
    .if_pa      (if_pa),
    .if_viol    (if_viol),
    .dt_la      (dt_la),
    .dt_pa      (dt_pa),
    .dt_viol    (dt_viol),
    .illegal_wr (illegal_wr)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input int sel, input int data, input logic p);
    @(negedge clk);
    priv    = p;
    wr_en   = 1'b1;
    wr_sel  = 2'(sel);
    wr_data = PA_W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
    priv    = 1'b0;
    if (p) begin
      case (sel)
        0: m_pb = data % NPA;
        1: m_pl = data % (2 * NLA);
        2: m_db = data % NPA;
        default: m_dl = data % (2 * NLA);
      endcase
    end
  endtask

  // Sweep every fetch address; data address walks a different order.
  task automatic sweep(input string req);
    for (int a = 0; a < NLA; a++) begin
      int d;
      int ev_i, ev_d, ep_i, ep_d;
      d = (a * 7 + 3) % NLA;
      @(negedge clk);
      if_la = LA_W'(a);
      dt_la = LA_W'(d);
      #1;
      ev_i = (a >= m_pl) ? 1 : 0;
      ev_d = (d >= m_dl) ? 1 : 0;
      ep_i = ev_i ? 0 : (m_pb + a) % NPA;  // R1 R6
      ep_d = ev_d ? 0 : (m_db + d) % NPA;
      check({req, " R2"}, "if_viol", int'(if_viol), ev_i);
      check({req, " R2"}, "dt_viol", int'(dt_viol), ev_d);
      check({req, " R1/R6 R3"}, "if_pa", int'(if_pa), ep_i);
      check({req, " R1/R6 R3"}, "dt_pa", int'(dt_pa), ep_d);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    compared = 0; mismatched = 0;
    m_pb = 0; m_pl = 0; m_db = 0; m_dl = 0;
    rst_n = 1'b0; priv = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    if_la = '0; dt_la = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: after reset everything faults
    check("R7", "illegal_wr", int'(illegal_wr), 0);
    sweep("R7");

    // R4: program both segments, distinct settings
    write_reg(0, 10, 1'b1);
    write_reg(1, 9, 1'b1);
    write_reg(2, 40, 1'b1);
    write_reg(3, 5, 1'b1);
    sweep("R4 cfgA");

    // R1 wrap: base near top of physical space, full-range limit
    write_reg(0, 60, 1'b1);
    write_reg(1, 16, 1'b1);
    write_reg(2, 55, 1'b1);
    write_reg(3, 15, 1'b1);
    sweep("R1 wrap");

    // R3: change only data pair, program side must be unaffected
    write_reg(2, 0, 1'b1);
    write_reg(3, 1, 1'b1);
    sweep("R3 split");

    // R4: limit takes low LA_W+1 bits (0b100010 -> 2)
    write_reg(1, 34, 1'b1);
    sweep("R4 trunc");

    // R5: unprivileged writes to each register are ignored
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      priv = 1'b0; wr_en = 1'b1; wr_sel = 2'(s); wr_data = 6'd7;
      @(negedge clk);
      wr_en = 1'b0;
      check("R5", "illegal_wr pulse", int'(illegal_wr), 1);
      @(negedge clk);
      check("R5", "illegal_wr drop", int'(illegal_wr), 0);
    end
    sweep("R5 ignored");

    // R5: privileged write gives no pulse
    write_reg(3, 12, 1'b1);
    check("R5", "no pulse on privileged write", int'(illegal_wr), 0);
    sweep("R4 final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule